// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block steps a system through a change of its clock frequency. Software picks a target rate by writing a one-hot code into a control register. When the write raises a single code bit that was clear before, the sequencer starts. It pulls the freeze request low and waits for the frozen devices to acknowledge. It then drives a timed handshake in order: the active-low clock-change strobes go low, the PLL bypass goes high, the strobes return high, and after a settle period the freeze and the bypass are both released.

A separate latency timer starts when the strobes are released. It marks the first cycle at the new rate with a one-cycle pulse. Each gap in the handshake has its own programmable count, and every count is in cycles of the block clock. The block clock runs at half the system rate.

Software is expected to clear the control register shortly after setting it. That clear, and any write that does not raise exactly one valid code bit, leaves the sequencer alone. The register bus is a plain single-cycle write port with a combinational read port, so it has no back-pressure. The PLL and the clock dividers are outside this block.

Top module: `freq_switch_seq`

## Requirements
- R1: After reset the outputs are idle: freeze_req_n = 1, clk_chg_n = 3'b111, pll_bypass = 0, new_freq_pulse = 0 and freq_sel = 0. Every register at addresses 0 to 6 reads back 0.
- R2: The control register is at address 0. Bit 0 selects full rate, bit 1 selects half rate and bit 5 selects 1/32 rate. A write to it starts a sequence when the three valid bits of the new value are one-hot and that bit was 0 in the stored value. The freeze_req_n output then reads 0 in the cycle after the write edge. In that same cycle, freq_sel shows the code as {bit5, bit1, bit0}.
- R3: The following control writes start nothing: a write with two or more valid bits set, a write of reserved bits only (mask 0xdc), a rewrite of the bit already stored, and a write of 0. In each case freeze_req_n stays 1.
- R4: The strobes stay high while the acknowledge is low. All three strobes go low max(ACT,1) cycles after the edge that samples freeze_ack high. ACT is the 8-bit register at address 1.
- R5: pll_bypass rises max(ABT,1) cycles after the strobes fall. ABT is the 16-bit register at address 2.
- R6: The strobes return high max(HOLD,1) cycles after pll_bypass rises. HOLD is the 8-bit register at address 3.
- R7: freeze_req_n returns high max(SETTLE,1) cycles after the strobes return high, and pll_bypass falls in the same cycle. SETTLE is the 32-bit register at address 4.
- R8: new_freq_pulse is high for exactly one cycle, max(LAT,1) cycles after the strobes return high. LAT is the 32-bit register at address 5.
- R9: Bit 0 of the read-only status at address 6 reads 1 from the start of a sequence until freeze_req_n returns high. A control write that arrives while a sequence runs does not change freq_sel and does not start a further sequence.
- R10: Each register reads back only its own width. Writing all ones to addresses 1 to 5 reads back 0xff, 0xffff, 0xff, 0xffffffff and 0xffffffff. The control register reads back 0x23, and the status ignores writes.
- R11: pll_bypass and low strobes occur only while freeze_req_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (half system rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data |
| freeze_ack | input | 1 | Devices report they are frozen |
| freeze_req_n | output | 1 | Active-low freeze request |
| clk_chg_n | output | 3 | Active-low clock-change strobes |
| pll_bypass | output | 1 | PLL bypass enable |
| freq_sel | output | 3 | Target rate of the current or last change |
| new_freq_pulse | output | 1 | One-cycle mark of the first new-rate cycle |

## Verification
The embedded properties check the ordering of the handshake on every cycle. Bypass and low strobes never appear outside a freeze. The bypass only rises out of a strobe phase, and freeze is only released straight after a settle phase with the bypass still up. A start always makes the block busy, and the new-frequency pulse never lasts two cycles. Only the bench can show the exact spacing of each phase and the zero-counts-as-one rule, which it sweeps over many delay combinations. The bench also covers the filtering of multi-bit, reserved, repeated and clearing writes, and the ignoring of writes during a running sequence.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT_ACK,
    PH_ACT_DLY,
    PH_CHANGE,
    PH_BYPASS,
    PH_SETTLE
  } phase_e;

  localparam int unsigned RA_CTRL   = 0;
  localparam int unsigned RA_ACT    = 1;
  localparam int unsigned RA_ABT    = 2;
  localparam int unsigned RA_HOLD   = 3;
  localparam int unsigned RA_SETTLE = 4;
  localparam int unsigned RA_LAT    = 5;
  localparam int unsigned RA_STAT   = 6;

  localparam int unsigned CB_FULL = 0;
  localparam int unsigned CB_HALF = 1;
  localparam int unsigned CB_SLOW = 5;

endpackage

// File: rtl/fsc_regs.sv
module fsc_regs
  import fsc_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32,
  parameter int ACT_W    = 8,
  parameter int ABT_W    = 16,
  parameter int HOLD_W   = 8,
  parameter int SETTLE_W = 32,
  parameter int LAT_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                busy_i,
  output logic [ACT_W-1:0]    act_o,
  output logic [ABT_W-1:0]    abt_o,
  output logic [HOLD_W-1:0]   hold_o,
  output logic [SETTLE_W-1:0] settle_o,
  output logic [LAT_W-1:0]    lat_o,
  output logic                start_o,
  output logic [2:0]          code_o
);

  logic [2:0] ctl_q;
  logic [2:0] new_ctl;
  logic [2:0] rising;
  logic       ctl_wr;

  assign new_ctl = {wr_data[CB_SLOW], wr_data[CB_HALF], wr_data[CB_FULL]};
  assign rising  = new_ctl & ~ctl_q;
  assign ctl_wr  = wr_en && (wr_addr == ADDR_W'(RA_CTRL));
  assign start_o = ctl_wr && $onehot(new_ctl) && (rising == new_ctl) && !busy_i;
  assign code_o  = new_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      act_o    <= '0;
      abt_o    <= '0;
      hold_o   <= '0;
      settle_o <= '0;
      lat_o    <= '0;
    end else if (wr_en) begin
      if (ctl_wr)                              ctl_q    <= new_ctl;
      if (wr_addr == ADDR_W'(RA_ACT))    act_o    <= wr_data[ACT_W-1:0];
      if (wr_addr == ADDR_W'(RA_ABT))    abt_o    <= wr_data[ABT_W-1:0];
      if (wr_addr == ADDR_W'(RA_HOLD))   hold_o   <= wr_data[HOLD_W-1:0];
      if (wr_addr == ADDR_W'(RA_SETTLE)) settle_o <= wr_data[SETTLE_W-1:0];
      if (wr_addr == ADDR_W'(RA_LAT))    lat_o    <= wr_data[LAT_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(RA_CTRL)) begin
      rd_data[CB_FULL] = ctl_q[0];
      rd_data[CB_HALF] = ctl_q[1];
      rd_data[CB_SLOW] = ctl_q[2];
    end else if (rd_addr == ADDR_W'(RA_ACT))    rd_data = DATA_W'(act_o);
    else if (rd_addr == ADDR_W'(RA_ABT))        rd_data = DATA_W'(abt_o);
    else if (rd_addr == ADDR_W'(RA_HOLD))       rd_data = DATA_W'(hold_o);
    else if (rd_addr == ADDR_W'(RA_SETTLE))     rd_data = DATA_W'(settle_o);
    else if (rd_addr == ADDR_W'(RA_LAT))        rd_data = DATA_W'(lat_o);
    else if (rd_addr == ADDR_W'(RA_STAT))       rd_data[0] = busy_i;
  end

  // R2: an accepted trigger always makes the sequencer busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_i);

endmodule

// File: rtl/fsc_phase.sv
module fsc_phase
  import fsc_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int ACT_W    = 8,
  parameter int ABT_W    = 16,
  parameter int HOLD_W   = 8,
  parameter int SETTLE_W = 32,
  parameter int STROBE_N = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [2:0]          code_i,
  input  logic                ack_i,
  input  logic [ACT_W-1:0]    act_i,
  input  logic [ABT_W-1:0]    abt_i,
  input  logic [HOLD_W-1:0]   hold_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                freeze_n_o,
  output logic [STROBE_N-1:0] chg_n_o,
  output logic                bypass_o,
  output logic [2:0]          sel_o,
  output logic                busy_o,
  output logic                release_o
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_last;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] d);
    return (d == '0) ? CNT_W'(1) : d;
  endfunction

  assign cnt_last = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sel_o   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_WAIT_ACK;
          sel_o   <= code_i;
        end
        PH_WAIT_ACK: if (ack_i) begin
          phase_q <= PH_ACT_DLY;
          cnt_q   <= at_least_one(CNT_W'(act_i));
        end
        PH_ACT_DLY: if (cnt_last) begin
          phase_q <= PH_CHANGE;
          cnt_q   <= at_least_one(CNT_W'(abt_i));
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_CHANGE: if (cnt_last) begin
          phase_q <= PH_BYPASS;
          cnt_q   <= at_least_one(CNT_W'(hold_i));
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_BYPASS: if (cnt_last) begin
          phase_q <= PH_SETTLE;
          cnt_q   <= at_least_one(CNT_W'(settle_i));
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_SETTLE: if (cnt_last) phase_q <= PH_IDLE;
                   else cnt_q <= cnt_q - CNT_W'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign freeze_n_o = (phase_q == PH_IDLE);
  assign busy_o     = (phase_q != PH_IDLE);
  assign bypass_o   = (phase_q == PH_BYPASS) || (phase_q == PH_SETTLE);
  assign release_o  = (phase_q == PH_BYPASS) && cnt_last;

  for (genvar g = 0; g < STROBE_N; g++) begin : g_strobe
    assign chg_n_o[g] = !((phase_q == PH_CHANGE) || (phase_q == PH_BYPASS));
  end

  // R11: bypass only inside a freeze
  p_bypass_in_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_o |-> !freeze_n_o);
  // R11: strobes only inside a freeze
  p_strobe_in_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_n_o != '1) |-> !freeze_n_o);
  // R4: strobes fall only at the end of the post-acknowledge delay
  p_strobe_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_n_o[0]) |-> $past(phase_q == PH_ACT_DLY));
  // R5: bypass rises only out of the strobe phase
  p_bypass_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_o) |-> $past(chg_n_o == '0));
  // R7: freeze released only after settle, with strobes high and bypass up
  p_release_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze_n_o) |-> ($past(bypass_o) && $past(chg_n_o == '1) && !bypass_o));
  // R2: the held code is one-hot while busy
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $onehot(sel_o));

endmodule

// File: rtl/fsc_latency.sv
module fsc_latency #(
  parameter int LAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             pulse_o
);

  logic [LAT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      pulse_o <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= (lat_i == '0) ? LAT_W'(1) : lat_i;
      run_q   <= 1'b1;
      pulse_o <= 1'b0;
    end else if (run_q) begin
      if (cnt_q <= LAT_W'(1)) begin
        run_q   <= 1'b0;
        pulse_o <= 1'b1;
      end else begin
        cnt_q   <= cnt_q - LAT_W'(1);
        pulse_o <= 1'b0;
      end
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R8: the new-rate mark is a single-cycle pulse
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/freq_switch_seq.sv
module freq_switch_seq #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32,
  parameter int ACT_W    = 8,
  parameter int ABT_W    = 16,
  parameter int HOLD_W   = 8,
  parameter int SETTLE_W = 32,
  parameter int LAT_W    = 32,
  parameter int STROBE_N = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                freeze_ack,
  output logic                freeze_req_n,
  output logic [STROBE_N-1:0] clk_chg_n,
  output logic                pll_bypass,
  output logic [2:0]          freq_sel,
  output logic                new_freq_pulse
);

  localparam int W_A   = (ACT_W > ABT_W) ? ACT_W : ABT_W;
  localparam int W_B   = (W_A > HOLD_W) ? W_A : HOLD_W;
  localparam int CNT_W = (W_B > SETTLE_W) ? W_B : SETTLE_W;

  logic [ACT_W-1:0]    act_w;
  logic [ABT_W-1:0]    abt_w;
  logic [HOLD_W-1:0]   hold_w;
  logic [SETTLE_W-1:0] settle_w;
  logic [LAT_W-1:0]    lat_w;
  logic                start_w;
  logic [2:0]          code_w;
  logic                busy_w;
  logic                release_w;

  fsc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACT_W(ACT_W), .ABT_W(ABT_W),
    .HOLD_W(HOLD_W), .SETTLE_W(SETTLE_W), .LAT_W(LAT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy_i(busy_w), .act_o(act_w), .abt_o(abt_w), .hold_o(hold_w),
    .settle_o(settle_w), .lat_o(lat_w), .start_o(start_w), .code_o(code_w)
  );

  fsc_phase #(
    .CNT_W(CNT_W), .ACT_W(ACT_W), .ABT_W(ABT_W), .HOLD_W(HOLD_W),
    .SETTLE_W(SETTLE_W), .STROBE_N(STROBE_N)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .code_i(code_w),
    .ack_i(freeze_ack), .act_i(act_w), .abt_i(abt_w), .hold_i(hold_w),
    .settle_i(settle_w), .freeze_n_o(freeze_req_n), .chg_n_o(clk_chg_n),
    .bypass_o(pll_bypass), .sel_o(freq_sel), .busy_o(busy_w),
    .release_o(release_w)
  );

  fsc_latency #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .load_i(release_w), .lat_i(lat_w),
    .pulse_o(new_freq_pulse)
  );

endmodule

// File: tb/sim_freq_switch_seq.sv
`timescale 1ns/1ps
module sim_freq_switch_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        freeze_ack = 1'b0;
  logic        freeze_req_n;
  logic [2:0]  clk_chg_n;
  logic        pll_bypass;
  logic [2:0]  freq_sel;
  logic        new_freq_pulse;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  freq_switch_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .freeze_ack(freeze_ack), .freeze_req_n(freeze_req_n),
    .clk_chg_n(clk_chg_n), .pll_bypass(pll_bypass), .freq_sel(freq_sel),
    .new_freq_pulse(new_freq_pulse)
  );

  task automatic check(input string req, input string what,
                       input longint actual, input longint expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    rd_addr = 3'(addr);
    #1 data = rd_data;
  endtask

  function automatic longint mx(input longint v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic quiet(input string req, input int n);
    logic [31:0] st;
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!freeze_req_n) bad++;
    end
    rd(6, st);
    check(req, "no freeze after ignored write", bad, 0);
    check(req, "not busy after ignored write", st[0], 0);
  endtask

  task automatic run_seq(input longint a, input longint b, input longint h,
                         input longint s, input longint l,
                         input logic [31:0] code, input logic [2:0] sel);
    longint t_ack, t_chg = -1, t_byp = -1, t_rel = -1, t_frz = -1, t_pul = -1;
    int npul = 0;
    logic byp_at_frz = 1'b1;
    logic [31:0] st;
    logic [31:0] mid = 0;
    wr(1, 32'(a)); wr(2, 32'(b)); wr(3, 32'(h)); wr(4, 32'(s)); wr(5, 32'(l));
    wr(0, 0);
    wr(0, code);
    check("R2", "freeze request after trigger", freeze_req_n, 0);
    check("R2", "freq_sel after trigger", freq_sel, sel);
    repeat (2) @(negedge clk);
    check("R4", "strobes high before ack", clk_chg_n, 7);
    freeze_ack = 1'b1;
    t_ack = cyc + 1;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (t_chg < 0 && clk_chg_n == 3'b000) begin
        t_chg = cyc;
        rd(6, mid);
      end
      if (t_byp < 0 && pll_bypass) t_byp = cyc;
      if (t_chg >= 0 && t_rel < 0 && clk_chg_n == 3'b111) t_rel = cyc;
      if (t_rel >= 0 && t_frz < 0 && freeze_req_n) begin
        t_frz = cyc; byp_at_frz = pll_bypass;
      end
      if (new_freq_pulse) begin
        npul++;
        if (t_pul < 0) t_pul = cyc;
      end
      if (t_frz >= 0 && t_pul >= 0) break;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (new_freq_pulse) npul++;
    end
    freeze_ack = 1'b0;
    rd(6, st);
    check("R4", "ack to strobe delay", t_chg - t_ack, mx(a));
    check("R5", "strobe to bypass delay", t_byp - t_chg, mx(b));
    check("R6", "bypass to strobe release", t_rel - t_byp, mx(h));
    check("R7", "release to freeze off", t_frz - t_rel, mx(s));
    check("R7", "bypass low at freeze off", byp_at_frz, 0);
    check("R8", "release to new-rate pulse", t_pul - t_rel, mx(l));
    check("R8", "pulse count", npul, 1);
    check("R9", "busy mid sequence", mid[0], 1);
    check("R9", "idle after sequence", st[0], 0);
  endtask

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] codes [3];
    logic [2:0]  sels [3];
    int k = 0;
    codes[0] = 32'h01; codes[1] = 32'h02; codes[2] = 32'h20;
    sels[0]  = 3'b001; sels[1]  = 3'b010; sels[2]  = 3'b100;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "freeze_req_n", freeze_req_n, 1);
    check("R1", "clk_chg_n", clk_chg_n, 7);
    check("R1", "pll_bypass", pll_bypass, 0);
    check("R1", "new_freq_pulse", new_freq_pulse, 0);
    check("R1", "freq_sel", freq_sel, 0);
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      check("R1", "register reset value", v, 0);
    end

    // R3 filtered control writes
    wr(0, 32'h03);  quiet("R3", 4);
    wr(0, 32'h00);  wr(0, 32'h21); quiet("R3", 4);
    wr(0, 32'h00);  wr(0, 32'hdc); quiet("R3", 4);

    // R10 readback widths
    for (int a = 1; a < 6; a++) wr(a, 32'hffff_ffff);
    rd(1, v); check("R10", "ACT width", v, 32'hff);
    rd(2, v); check("R10", "ABT width", v, 32'hffff);
    rd(3, v); check("R10", "HOLD width", v, 32'hff);
    rd(4, v); check("R10", "SETTLE width", v, 32'hffff_ffff);
    rd(5, v); check("R10", "LAT width", v, 32'hffff_ffff);
    wr(0, 32'hff); rd(0, v); check("R10", "control width", v, 32'h23);
    quiet("R3", 2);
    wr(6, 32'hffff_ffff); rd(6, v); check("R10", "status ignores write", v, 0);

    // R4..R9 sweep over delay combinations
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int h = 0; h < 4; h += 2)
          for (int s = 1; s < 4; s += 2)
            for (int l = 1; l < 6; l += 4) begin
              run_seq(a, b, h, s, l, codes[k % 3], sels[k % 3]);
              k++;
            end

    // R3 rewrite of stored bit and clear write
    run_seq(1, 1, 1, 1, 1, 32'h01, 3'b001);
    wr(0, 32'h01); quiet("R3", 4);
    wr(0, 32'h00); quiet("R3", 4);
    // R2 switching directly from one code to another
    wr(1, 1); wr(2, 1); wr(3, 1); wr(4, 1); wr(5, 1);
    wr(0, 32'h02);
    check("R2", "code change starts", freeze_req_n, 0);
    check("R2", "freq_sel on change", freq_sel, 3'b010);
    freeze_ack = 1'b1;
    repeat (12) @(negedge clk);
    freeze_ack = 1'b0;
    check("R7", "change finished", freeze_req_n, 1);

    // R9 writes during a sequence are ignored
    wr(4, 8);
    wr(0, 32'h00);
    wr(0, 32'h20);
    wr(0, 32'h00);
    wr(0, 32'h01);
    check("R9", "freq_sel kept while busy", freq_sel, 3'b100);
    freeze_ack = 1'b1;
    for (int n = 0; n < 60 && !freeze_req_n; n++) @(negedge clk);
    freeze_ack = 1'b0;
    check("R9", "sequence completed", freeze_req_n, 1);
    check("R9", "freq_sel unchanged", freq_sel, 3'b100);
    quiet("R9", 6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule